// File: doc/BRIEF.md
# Byte-Lane Static Memory with Control-Mode Decoding

This block is a clocked, synthesizable model of a word-organised static memory with two independently selectable byte lanes. On every rising clock edge it samples five active-low controls (chip enable, write strobe, output enable and one select per byte lane) together with an address and write data. It decodes them into one of four modes: read, write, output-off or deselected. The full device holds 65536 words of 16 bits. For that size, set `ADDR_W` to 16. The default is 10 address bits, which keeps elaboration small.

Each byte lane has its own write-data slice, read-data slice and a drive flag that stands in for a three-state pin group. A lane drives only when it is selected in a read cycle. In every other case its drive flag is low and its read-data slice is zero. A standby output reports that the chip enable was high at the last edge. The controls are plain level signals sampled every cycle, so the data paths carry no handshake and there is no back-pressure.

Top module: `sram_lane_mem`

## Requirements
- R1: While `rst_n` is low, `rd_drv` is 0, `rdata` is 0, `standby` is 1 and `mode` is 0 (deselected).
- R2: A write stores the selected lanes' slices of `wdata` at `addr`; lanes whose select is high keep their old contents. Lane 0 is bits 7:0 and is selected by `lane_sel_n[0]`; lane 1 is bits 15:8 and is selected by `lane_sel_n[1]`.
- R3: With `cs_n`=0, `we_n`=1, `oe_n`=0 and at least one lane select low, each selected lane shows the stored byte on `rdata` and raises its `rd_drv` bit after the sampling edge. An unselected lane does not drive. `mode` is 2.
- R4: With `cs_n`=0, `we_n`=1, `oe_n`=1 and at least one lane select low, neither lane drives and `mode` is 1 (output off).
- R5: A write (`cs_n`=0, `we_n`=0, at least one lane select low) drives no lane, whatever the level of `oe_n`. `mode` is 3.
- R6: With `cs_n`=1, or with both lane selects high, nothing is written, neither lane drives and `mode` is 0.
- R7: `standby` equals the `cs_n` sampled at the previous edge.
- R8: A lane whose `rd_drv` bit is 0 shows zero on its `rdata` slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lane_sel_n | input | LANES (2) | Per-lane byte select, active low |
| addr | input | ADDR_W (10) | Word address |
| wdata | input | LANES*LANE_W (16) | Write data, lane 0 in the low byte |
| rdata | output | LANES*LANE_W (16) | Read data, zero in lanes that do not drive |
| rd_drv | output | LANES (2) | Per-lane drive flag (stands in for the three-state enable) |
| standby | output | 1 | High when the device was deselected by `cs_n` |
| mode | output | 2 | Decoded mode: 0 deselected, 1 output off, 2 read, 3 write |

## Verification
A write request and an output-enable request can arrive in the same cycle: `we_n` and `oe_n` are both low, and the write must win. The bench sweeps all 32 combinations of the five controls at several addresses, so this collision occurs repeatedly with each lane-select pattern. It also meets the case where `cs_n` is high while the other controls request a read or a write. Each cycle is judged against an arithmetic reference model held in the bench. The model checks mode, drive flags, read data and standby. After each sweep step the bench reads the touched word back with both lanes selected. This shows through the ports whether the lanes that should stay untouched kept their old contents.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL = 2'd0,
    MODE_OFF   = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_lane_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_sel_n,
  output sram_mode_e       mode,
  output logic [LANES-1:0] lane_wr,
  output logic [LANES-1:0] lane_rd
);
  logic any_lane;

  assign any_lane = (lane_sel_n != {LANES{1'b1}});

  // Priority: deselect, then write, then output off, then read.
  always_comb begin
    mode    = MODE_DESEL;
    lane_wr = '0;
    lane_rd = '0;
    if (!cs_n && any_lane) begin
      if (!we_n) begin
        mode    = MODE_WRITE;
        lane_wr = ~lane_sel_n;
      end else if (oe_n) begin
        mode = MODE_OFF;
      end else begin
        mode    = MODE_READ;
        lane_rd = ~lane_sel_n;
      end
    end
  end
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata,
  output logic              drv
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      drv   <= 1'b0;
    end else if (rd_en) begin
      rdata <= cells[addr];
      drv   <= 1'b1;
    end else begin
      rdata <= '0;
      drv   <= 1'b0;
    end
  end

  AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !drv |-> (rdata == '0)); // R8
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> drv); // R3
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !drv); // R5
endmodule

// File: rtl/sram_lane_mem.sv
module sram_lane_mem
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        rd_drv,
  output logic                    standby,
  output logic [1:0]              mode
);
  sram_mode_e       dec_mode;
  sram_mode_e       mode_q;
  logic [LANES-1:0] lane_wr;
  logic [LANES-1:0] lane_rd;

  sram_mode_decode #(.LANES(LANES)) u_decode (
    .cs_n       (cs_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .lane_sel_n (lane_sel_n),
    .mode       (dec_mode),
    .lane_wr    (lane_wr),
    .lane_rd    (lane_rd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (lane_wr[g]),
      .rd_en (lane_rd[g]),
      .addr  (addr),
      .wdata (wdata[g*LANE_W +: LANE_W]),
      .rdata (rdata[g*LANE_W +: LANE_W]),
      .drv   (rd_drv[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_DESEL;
      standby <= 1'b1;
    end else begin
      mode_q  <= dec_mode;
      standby <= cs_n;
    end
  end

  assign mode = mode_q;

  AST_STANDBY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (standby == $past(cs_n))); // R7
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || lane_sel_n == {LANES{1'b1}}) |=> (rd_drv == '0 && mode == 2'd0)); // R6
  AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && oe_n) |=> (rd_drv == '0)); // R4
  AST_WRITE_OVER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n && !oe_n && lane_sel_n != {LANES{1'b1}}) |=> (rd_drv == '0 && mode == 2'd3)); // R5
endmodule

// File: tb/test_sram_lane_mem.sv
module test_sram_lane_mem;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  lane_sel_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  rd_drv;
  logic        standby;
  logic [1:0]  mode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [15:0] ref_mem [DEPTH];

  always #5 clk = ~clk;

  sram_lane_mem #(.ADDR_W(AW), .LANE_W(8), .LANES(2)) i_sram_lane_mem (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .lane_sel_n(lane_sel_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_drv(rd_drv), .standby(standby), .mode(mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One sampled cycle: drive at negedge, check at the following negedge.
  task automatic step(input logic c, input logic w, input logic o,
                      input logic [1:0] s, input logic [AW-1:0] a,
                      input logic [15:0] d);
    logic [1:0]  e_mode;
    logic [1:0]  e_drv;
    logic [15:0] e_data;
    string tag;
    cs_n = c; we_n = w; oe_n = o; lane_sel_n = s; addr = a; wdata = d;
    e_drv = 2'b00; e_data = 16'h0000;
    if (c || s == 2'b11) begin
      e_mode = 2'd0; tag = "R6";
    end else if (!w) begin
      e_mode = 2'd3; tag = "R5";
      if (!s[0]) ref_mem[a][7:0]  = d[7:0];
      if (!s[1]) ref_mem[a][15:8] = d[15:8];
    end else if (o) begin
      e_mode = 2'd1; tag = "R4";
    end else begin
      e_mode = 2'd2; tag = "R3";
      e_drv = ~s;
      if (!s[0]) e_data[7:0]  = ref_mem[a][7:0];
      if (!s[1]) e_data[15:8] = ref_mem[a][15:8];
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " mode"}, 32'(mode), 32'(e_mode));
    chk({tag, " rd_drv"}, 32'(rd_drv), 32'(e_drv));
    chk({tag, "/R2/R8 rdata"}, 32'(rdata), 32'(e_data));
    chk("R7 standby", 32'(standby), 32'(c));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, controls requesting a read while held in reset
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; lane_sel_n = 2'b00;
    @(posedge clk); @(negedge clk);
    chk("R1 rd_drv", 32'(rd_drv), 32'h0);
    chk("R1 rdata", 32'(rdata), 32'h0);
    chk("R1 standby", 32'(standby), 32'h1);
    chk("R1 mode", 32'(mode), 32'h0);
    rst_n = 1'b1;

    // R2 fill every word, then read every word back
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, 1'b0, 1'b1, 2'b00, AW'(a), 16'(a * 16'h3B + 16'h1234));
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, 1'b1, 1'b0, 2'b00, AW'(a), 16'hFFFF);

    // All 32 control combinations at several addresses, each followed by a full-word read
    for (int k = 0; k < 32; k++) begin
      for (int j = 0; j < 4; j++) begin
        logic [AW-1:0] a;
        a = (j == 0) ? AW'(0) : (j == 1) ? AW'(1) : (j == 2) ? AW'(DEPTH/2 + 1) : AW'(DEPTH - 1);
        step(k[4], k[3], k[2], k[1:0], a, 16'(k * 16'h0A53 + j * 16'h1111 + 16'h5A));
        step(1'b0, 1'b1, 1'b0, 2'b00, a, 16'h0);
      end
    end

    // R2 back-to-back lane writes then a read of one lane only
    step(1'b0, 1'b0, 1'b0, 2'b10, AW'(7), 16'hAB_CD);
    step(1'b0, 1'b0, 1'b0, 2'b01, AW'(7), 16'hEF_12);
    step(1'b0, 1'b1, 1'b0, 2'b10, AW'(7), 16'h0);
    step(1'b0, 1'b1, 1'b0, 2'b01, AW'(7), 16'h0);
    step(1'b0, 1'b1, 1'b0, 2'b00, AW'(7), 16'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule